// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block watches the command bus between a memory controller and a four-bank double-data-rate graphics DRAM. It reports, in the same cycle, whether the command on the bus respects the device's minimum spacing rules. Each cycle it decodes the active-low chip-select, row-strobe, column-strobe and write-enable levels, the bank address and the auto-precharge/all-banks bit (A10). It compares the command against a set of countdown timers. Some timers are kept for each bank and others apply to the whole device.

All minimums are parameters given in clock cycles. Their defaults are the fastest speed grade at read latency 4: row cycle 16, refresh cycle 17, minimum row-active 11, activate-to-read 5, activate-to-write 3, precharge 5, activate-to-activate 3, write recovery 4, write-recovery-plus-precharge 9 and mode-write spacing 2. The write activate-to-column delay is never taken below 2 cycles. A two-bit burst-length input sets how long a write burst lasts. The checker is passive. It has a legal flag and a violation code as outputs and drives nothing on the memory bus.

Top module: `ddr_cmd_checker`

## Requirements
- R1: With `cs_n` high, and for the no-operation and burst-stop encodings (`ras_n`,`cas_n`,`we_n` = 111 or 110), the cycle is legal with code 0. Commands are decoded as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write.
- R2: After the synchronous active-low reset, all banks are idle and all timers are zero, so the first activate is legal.
- R3: A read or write to an idle bank gives code 9.
- R4: A read fewer than `T_RCD_RD` cycles after its bank's activate, or a write fewer than `T_RCD_WR` cycles after it (never less than 2), gives code 1.
- R5: A precharge of an open bank fewer than `T_RAS` cycles after its activate gives code 3. A precharge of an idle bank is legal and changes no timer.
- R6: An activate fewer than `T_RP` cycles after its bank was precharged gives code 2. An activate to an already open bank gives code 10.
- R7: Activates to the same bank closer than `T_RC` cycles give code 4. Activates to any two banks closer than `T_RRD` cycles give code 5.
- R8: `bl_code` selects the burst length: 01 means 2 beats, 10 means 4, 11 means 8, and 00 is treated as 2. A burst takes half as many cycles as it has beats. A precharge of a bank sooner than burst cycles plus `T_WR` after a write to that bank gives code 6.
- R9: A write with A10=1 leaves its bank idle at once. An activate to that bank sooner than burst cycles plus `T_DAL` after the write gives code 6. A read with A10=1 also leaves its bank idle. The bank's next activate must then wait the larger of the remaining minimum row-active time and the burst cycles, plus `T_RP`. An earlier activate gives code 2.
- R10: A mode-register write with any bank open gives code 8. While an auto-precharge is still in flight it gives code 6, and while a precharge is still in flight it gives code 2. Any command within `T_MRD` cycles after a mode write gives code 7.
- R11: A refresh with any bank open gives code 8. Any command within `T_RFC` cycles after a refresh gives code 11.
- R12: Checks are applied in a fixed order. Mode-write spacing comes first, then refresh spacing, then the command's own checks, in the order listed in R6/R9/R7 for activate. An illegal command changes no state.
- R13: A precharge with A10=1 applies to every open bank. It is checked against each of them, and the lowest-numbered failing bank supplies the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| bl_code | input | 2 | Burst-length select |
| cmd_ok | output | 1 | High when the current cycle is legal |
| viol_code | output | 4 | Violation code, 0 when legal |

## Verification
The bound assertions check, on every cycle, properties that hold for any command stream. A no-op is always legal. Accesses to idle banks and mode writes with open banks are always rejected. Back-to-back activates, activate-then-precharge and command-after-mode-write are never accepted together. A rejected command never changes which banks are open. The exact countdown lengths are shown only by the bench's directed timeline, which steps each rule one cycle before and at its limit. These include the write-recovery and auto-precharge windows that depend on burst length, the delayed close after an auto-precharge read, the precharge-all fan-out and the order in which overlapping violations are reported.

// File: rtl/ddrchk_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM command timing checker.
package ddrchk_pkg;

    // Decoded command kinds
    typedef enum logic [2:0] {
        K_NOP = 3'd0,
        K_ACT = 3'd1,
        K_RD  = 3'd2,
        K_WR  = 3'd3,
        K_PRE = 3'd4,
        K_REF = 3'd5,
        K_MRS = 3'd6
    } cmd_e;

    // Violation codes reported on viol_code
    typedef enum logic [3:0] {
        V_NONE = 4'd0,
        V_RCD  = 4'd1,
        V_RP   = 4'd2,
        V_RAS  = 4'd3,
        V_RC   = 4'd4,
        V_RRD  = 4'd5,
        V_WREC = 4'd6,
        V_MRD  = 4'd7,
        V_BUSY = 4'd8,
        V_IDLE = 4'd9,
        V_OPEN = 4'd10,
        V_RFC  = 4'd11
    } viol_e;

endpackage

// File: rtl/ddrchk_decode.sv
`timescale 1ns/1ps
// Command decoder: turns the active-low strobe levels into a command kind.
// Assumes inputs are already synchronous to clk; burst stop maps to no-op.
module ddrchk_decode
    import ddrchk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);
    // Map the strobe pattern to a command kind
    always_comb begin
        if (cs_n) begin
            cmd_o = K_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd_o = K_ACT;
                3'b101:  cmd_o = K_RD;
                3'b100:  cmd_o = K_WR;
                3'b010:  cmd_o = K_PRE;
                3'b001:  cmd_o = K_REF;
                3'b000:  cmd_o = K_MRS;
                default: cmd_o = K_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrchk_bank.sv
`timescale 1ns/1ps
// Per-bank tracker: open/idle flag plus countdown timers for one bank.
// Assumes the strobes are pulsed only for commands already judged legal.
// A timer loaded with N-1 reaches zero N cycles after the command.
module ddrchk_bank #(
    parameter int TW       = 6,
    parameter int T_RCD_RD = 5,
    parameter int T_RCD_WR = 3,
    parameter int T_RAS    = 11,
    parameter int T_RC     = 16,
    parameter int T_RP     = 5,
    parameter int T_WR     = 4,
    parameter int T_DAL    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          pre_i,
    input  logic          ap_i,
    input  logic [TW-1:0] blc_i,
    output logic          open_o,
    output logic          rcd_rd_ok_o,
    output logic          rcd_wr_ok_o,
    output logic          ras_ok_o,
    output logic          rc_ok_o,
    output logic          rp_ok_o,
    output logic          wr_ok_o,
    output logic          dal_ok_o
);
    localparam logic [TW-1:0] L_RCD_RD = TW'(T_RCD_RD - 1);
    localparam logic [TW-1:0] L_RCD_WR = TW'(T_RCD_WR - 1);
    localparam logic [TW-1:0] L_RAS    = TW'(T_RAS - 1);
    localparam logic [TW-1:0] L_RC     = TW'(T_RC - 1);
    localparam logic [TW-1:0] L_RP     = TW'(T_RP - 1);
    localparam logic [TW-1:0] L_WR     = TW'(T_WR - 1);
    localparam logic [TW-1:0] L_DAL    = TW'(T_DAL - 1);

    logic [TW-1:0] rcd_rd_q, rcd_wr_q, ras_q, rc_q, rp_q, wr_q, dal_q;
    logic [TW-1:0] ras_span;

    // Saturating one-step countdown
    function automatic logic [TW-1:0] dn(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    // Longer of remaining row-active time and burst for an auto-precharge read
    always_comb ras_span = (ras_q > blc_i) ? ras_q : blc_i;

    // Bank open/idle state
    always_ff @(posedge clk) begin
        if (!rst_n)                   open_o <= 1'b0;
        else if (act_i)               open_o <= 1'b1;
        else if (pre_i)               open_o <= 1'b0;
        else if ((rd_i || wr_i) && ap_i) open_o <= 1'b0;
    end

    // Timers started by activate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_rd_q <= '0; rcd_wr_q <= '0; ras_q <= '0; rc_q <= '0;
        end else if (act_i) begin
            rcd_rd_q <= L_RCD_RD; rcd_wr_q <= L_RCD_WR;
            ras_q <= L_RAS; rc_q <= L_RC;
        end else begin
            rcd_rd_q <= dn(rcd_rd_q); rcd_wr_q <= dn(rcd_wr_q);
            ras_q <= dn(ras_q); rc_q <= dn(rc_q);
        end
    end

    // Precharge timer: explicit precharge or auto-precharge read
    always_ff @(posedge clk) begin
        if (!rst_n)              rp_q <= '0;
        else if (pre_i)          rp_q <= L_RP;
        else if (rd_i && ap_i)   rp_q <= ras_span + L_RP;
        else                     rp_q <= dn(rp_q);
    end

    // Write recovery timers: to precharge, and to activate after auto-precharge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0; dal_q <= '0;
        end else begin
            wr_q  <= wr_i ? (blc_i + L_WR) : dn(wr_q);
            dal_q <= (wr_i && ap_i) ? (blc_i + L_DAL) : dn(dal_q);
        end
    end

    assign rcd_rd_ok_o = (rcd_rd_q == '0);
    assign rcd_wr_ok_o = (rcd_wr_q == '0);
    assign ras_ok_o    = (ras_q == '0);
    assign rc_ok_o     = (rc_q == '0);
    assign rp_ok_o     = (rp_q == '0);
    assign wr_ok_o     = (wr_q == '0);
    assign dal_ok_o    = (dal_q == '0);
endmodule

// File: rtl/ddrchk_dev.sv
`timescale 1ns/1ps
// Device-wide timers: activate-to-activate, refresh cycle, mode-write spacing.
// Assumes strobes are pulsed only for legal commands.
module ddrchk_dev #(
    parameter int TW    = 6,
    parameter int T_RRD = 3,
    parameter int T_RFC = 17,
    parameter int T_MRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic ref_i,
    input  logic mrs_i,
    output logic rrd_ok_o,
    output logic rfc_ok_o,
    output logic mrd_ok_o
);
    localparam logic [TW-1:0] L_RRD = TW'(T_RRD - 1);
    localparam logic [TW-1:0] L_RFC = TW'(T_RFC - 1);
    localparam logic [TW-1:0] L_MRD = TW'(T_MRD - 1);

    logic [TW-1:0] rrd_q, rfc_q, mrd_q;

    function automatic logic [TW-1:0] dn(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    // Load on the matching command, otherwise count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0; rfc_q <= '0; mrd_q <= '0;
        end else begin
            rrd_q <= act_i ? L_RRD : dn(rrd_q);
            rfc_q <= ref_i ? L_RFC : dn(rfc_q);
            mrd_q <= mrs_i ? L_MRD : dn(mrd_q);
        end
    end

    assign rrd_ok_o = (rrd_q == '0);
    assign rfc_ok_o = (rfc_q == '0);
    assign mrd_ok_o = (mrd_q == '0);
endmodule

// File: rtl/ddrchk_judge.sv
`timescale 1ns/1ps
// Rule engine: picks the first violated rule for the current command.
// Purely combinational; order is mode spacing, refresh spacing, then per command.
module ddrchk_judge
    import ddrchk_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  cmd_e            cmd_i,
    input  logic [BA_W-1:0] ba_i,
    input  logic            a10_i,
    input  logic [NB-1:0]   open_i,
    input  logic [NB-1:0]   rcd_rd_ok_i,
    input  logic [NB-1:0]   rcd_wr_ok_i,
    input  logic [NB-1:0]   ras_ok_i,
    input  logic [NB-1:0]   rc_ok_i,
    input  logic [NB-1:0]   rp_ok_i,
    input  logic [NB-1:0]   wr_ok_i,
    input  logic [NB-1:0]   dal_ok_i,
    input  logic            rrd_ok_i,
    input  logic            rfc_ok_i,
    input  logic            mrd_ok_i,
    output viol_e           viol_o
);
    logic [NB-1:0] pre_mask;
    viol_e         pre_code;

    // Banks addressed by a precharge
    always_comb begin
        pre_mask = '0;
        pre_mask[ba_i] = 1'b1;
        if (a10_i) pre_mask = '1;
    end

    // Precharge rule over every addressed open bank; lowest index wins
    always_comb begin
        pre_code = V_NONE;
        for (int b = NB - 1; b >= 0; b--) begin
            if (pre_mask[b] && open_i[b]) begin
                if (!ras_ok_i[b])     pre_code = V_RAS;
                else if (!wr_ok_i[b]) pre_code = V_WREC;
            end
        end
    end

    // First failing rule for the decoded command
    always_comb begin
        viol_o = V_NONE;
        if (cmd_i != K_NOP) begin
            if (!mrd_ok_i)      viol_o = V_MRD;
            else if (!rfc_ok_i) viol_o = V_RFC;
            else begin
                unique case (cmd_i)
                    K_ACT: begin
                        if (open_i[ba_i])         viol_o = V_OPEN;
                        else if (!dal_ok_i[ba_i]) viol_o = V_WREC;
                        else if (!rp_ok_i[ba_i])  viol_o = V_RP;
                        else if (!rc_ok_i[ba_i])  viol_o = V_RC;
                        else if (!rrd_ok_i)       viol_o = V_RRD;
                    end
                    K_RD: begin
                        if (!open_i[ba_i])           viol_o = V_IDLE;
                        else if (!rcd_rd_ok_i[ba_i]) viol_o = V_RCD;
                    end
                    K_WR: begin
                        if (!open_i[ba_i])           viol_o = V_IDLE;
                        else if (!rcd_wr_ok_i[ba_i]) viol_o = V_RCD;
                    end
                    K_PRE: viol_o = pre_code;
                    K_REF, K_MRS: begin
                        if (|open_i)           viol_o = V_BUSY;
                        else if (!(&dal_ok_i)) viol_o = V_WREC;
                        else if (!(&rp_ok_i))  viol_o = V_RP;
                    end
                    default: viol_o = V_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ddr_cmd_checker.sv
`timescale 1ns/1ps
// Top: DRAM command timing checker. Decodes the command bus, judges it
// against bank and device timers, and updates state only for legal commands.
// Assumes one command per clock and all minimums of at least one cycle.
module ddr_cmd_checker
    import ddrchk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RC      = 16,
    parameter int T_RFC     = 17,
    parameter int T_RAS     = 11,
    parameter int T_RCD_RD  = 5,
    parameter int T_RCD_WR  = 3,
    parameter int T_RP      = 5,
    parameter int T_RRD     = 3,
    parameter int T_WR      = 4,
    parameter int T_DAL     = 9,
    parameter int T_MRD     = 2,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic [1:0]      bl_code,
    output logic            cmd_ok,
    output logic [3:0]      viol_code
);
    localparam int T_RCD_WR_EFF = (T_RCD_WR < 2) ? 2 : T_RCD_WR;
    localparam int T_SUM = T_RC + T_RFC + T_RAS + T_RP + T_WR + T_DAL
                         + T_RCD_RD + T_RCD_WR_EFF + T_RRD + T_MRD + 8;
    localparam int TW = $clog2(T_SUM + 1);

    cmd_e            cmd;
    viol_e           viol;
    logic            legal_cmd;
    logic [TW-1:0]   blc;
    logic [NUM_BANKS-1:0] bank_open, rcd_rd_ok, rcd_wr_ok, ras_ok, rc_ok;
    logic [NUM_BANKS-1:0] rp_ok, wr_ok, dal_ok;
    logic            rrd_ok, rfc_ok, mrd_ok;

    ddrchk_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd)
    );

    // Burst duration in clock cycles from the length select
    always_comb begin
        unique case (bl_code)
            2'b10:   blc = TW'(2);
            2'b11:   blc = TW'(4);
            default: blc = TW'(1);
        endcase
    end

    // A real command that passed every rule
    assign legal_cmd = (cmd != K_NOP) && (viol == V_NONE);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = (ba == BA_W'(b));
            ddrchk_bank #(
                .TW(TW), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR_EFF),
                .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
                .T_WR(T_WR), .T_DAL(T_DAL)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .act_i(legal_cmd && cmd == K_ACT && hit),
                .rd_i (legal_cmd && cmd == K_RD  && hit),
                .wr_i (legal_cmd && cmd == K_WR  && hit),
                .pre_i(legal_cmd && cmd == K_PRE && (hit || a10) && bank_open[b]),
                .ap_i (a10),
                .blc_i(blc),
                .open_o(bank_open[b]),
                .rcd_rd_ok_o(rcd_rd_ok[b]), .rcd_wr_ok_o(rcd_wr_ok[b]),
                .ras_ok_o(ras_ok[b]), .rc_ok_o(rc_ok[b]), .rp_ok_o(rp_ok[b]),
                .wr_ok_o(wr_ok[b]), .dal_ok_o(dal_ok[b])
            );
        end
    endgenerate

    ddrchk_dev #(.TW(TW), .T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_dev (
        .clk(clk), .rst_n(rst_n),
        .act_i(legal_cmd && cmd == K_ACT),
        .ref_i(legal_cmd && cmd == K_REF),
        .mrs_i(legal_cmd && cmd == K_MRS),
        .rrd_ok_o(rrd_ok), .rfc_ok_o(rfc_ok), .mrd_ok_o(mrd_ok)
    );

    ddrchk_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
        .cmd_i(cmd), .ba_i(ba), .a10_i(a10), .open_i(bank_open),
        .rcd_rd_ok_i(rcd_rd_ok), .rcd_wr_ok_i(rcd_wr_ok), .ras_ok_i(ras_ok),
        .rc_ok_i(rc_ok), .rp_ok_i(rp_ok), .wr_ok_i(wr_ok), .dal_ok_i(dal_ok),
        .rrd_ok_i(rrd_ok), .rfc_ok_i(rfc_ok), .mrd_ok_i(mrd_ok), .viol_o(viol)
    );

    assign viol_code = viol;
    assign cmd_ok    = (viol == V_NONE);
endmodule

// File: rtl/ddrchk_props.sv
`timescale 1ns/1ps
// Assertion checker for ddr_cmd_checker, attached by bind below.
module ddrchk_props
    import ddrchk_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = 2,
    parameter int T_RAS = 11,
    parameter int T_RRD = 3,
    parameter int T_MRD = 2
) (
    input logic            clk,
    input logic            rst_n,
    input cmd_e            cmd,
    input logic [BA_W-1:0] ba,
    input logic            a10,
    input logic [NB-1:0]   bank_open,
    input logic            cmd_ok,
    input logic [3:0]      viol_code
);
    p_nop_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == K_NOP) |-> (cmd_ok && viol_code == 4'd0));

    p_idle_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == K_RD || cmd == K_WR) && !bank_open[ba]) |-> !cmd_ok);

    p_mrs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == K_MRS && |bank_open) |-> !cmd_ok);

    p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> (bank_open == $past(bank_open)));

    generate
        if (T_RRD > 1) begin : g_rrd
            p_rrd_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd == K_ACT && cmd_ok) |=> !(cmd == K_ACT && cmd_ok));
        end
        if (T_RAS > 1) begin : g_ras
            p_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd == K_ACT && cmd_ok) |=>
                !(cmd == K_PRE && (a10 || ba == $past(ba)) && cmd_ok));
        end
        if (T_MRD > 1) begin : g_mrd
            p_mrd_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd == K_MRS && cmd_ok) |=> (cmd == K_NOP || !cmd_ok));
        end
    endgenerate
endmodule

bind ddr_cmd_checker ddrchk_props #(
    .NB(NUM_BANKS), .BA_W(BA_W), .T_RAS(T_RAS), .T_RRD(T_RRD), .T_MRD(T_MRD)
) u_props (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .a10(a10),
    .bank_open(bank_open), .cmd_ok(cmd_ok), .viol_code(viol_code)
);

// File: tb/ddr_cmd_checker_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected code for every cycle,
// the monitor compares it with the outputs just before the next edge.
module ddr_cmd_checker_bench;
    localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3,
                   K_PRE = 4, K_REF = 5, K_MRS = 6;

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [1:0] bl_code = 2'b10;   // 4 beats = 2 cycles
    logic       cmd_ok;
    logic [3:0] viol_code;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ddr_cmd_checker #(.T_RC(20)) u_ddr_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .bl_code(bl_code),
        .cmd_ok(cmd_ok), .viol_code(viol_code)
    );

    // Drive one cycle with an explicit strobe pattern and queue its expectation
    task automatic raw(input logic c, input logic [2:0] rcw, input int b,
                       input logic a, input int code, input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); a10 = a;
        e.code = code; e.tag = tag;
        q.push_back(e);
    endtask

    // Drive one decoded command kind
    task automatic issue(input int k, input int b, input logic a,
                         input int code, input string tag);
        logic [2:0] p;
        case (k)
            K_ACT:   p = 3'b011;
            K_RD:    p = 3'b101;
            K_WR:    p = 3'b100;
            K_PRE:   p = 3'b010;
            K_REF:   p = 3'b001;
            K_MRS:   p = 3'b000;
            default: p = 3'b111;
        endcase
        raw(1'b0, p, b, a, code, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(K_NOP, 0, 1'b0, 0, "R1");
    endtask

    // Monitor: compare outputs away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (cmd_ok !== (e.code == 0) || viol_code !== 4'(e.code)) begin
                    n_fail++;
                    $display("FAIL %s: ok=%0b code=%0d expected ok=%0b code=%0d",
                             e.tag, cmd_ok, viol_code, (e.code == 0), e.code);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus timeline; tN marks the cycle index after the reset preamble
    initial begin
        // Reset: outputs legal while no command is on the bus (R2)
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        raw(1'b1, 3'b000, 0, 1'b0, 0, "R1 cs high");
        raw(1'b0, 3'b110, 0, 1'b0, 0, "R1 burst stop");
        issue(K_RD, 0, 1'b0, 9, "R2/R3 bank idle after reset");
        issue(K_WR, 1, 1'b0, 9, "R3 write idle bank");
        issue(K_ACT, 0, 1'b0, 0, "R2 first activate legal");      // t0
        issue(K_ACT, 1, 1'b0, 5, "R7 rrd");                        // t1
        issue(K_WR, 0, 1'b0, 1, "R4 write rcd");                   // t2
        issue(K_ACT, 1, 1'b0, 0, "R12 illegal act left no rrd");   // t3
        issue(K_RD, 0, 1'b0, 1, "R4 read rcd");                    // t4
        issue(K_RD, 0, 1'b0, 0, "R4 read at limit");               // t5
        issue(K_ACT, 0, 1'b0, 10, "R6 activate open bank");        // t6
        issue(K_PRE, 0, 1'b0, 3, "R5 ras");                        // t7
        issue(K_WR, 0, 1'b0, 0, "R4 write legal");                 // t8
        idle(2);                                                   // t9-t10
        issue(K_PRE, 0, 1'b0, 6, "R8 write recovery");             // t11
        issue(K_MRS, 0, 1'b0, 8, "R10 mode write bank open");      // t12
        issue(K_REF, 0, 1'b0, 8, "R11 refresh bank open");         // t13
        issue(K_PRE, 0, 1'b0, 0, "R8 recovery done");              // t14
        issue(K_ACT, 0, 1'b0, 2, "R6/R12 rp before rc");           // t15
        issue(K_PRE, 0, 1'b1, 0, "R13 precharge all");             // t16
        issue(K_ACT, 1, 1'b0, 2, "R13 bank1 closed by all");       // t17
        idle(1);                                                   // t18
        issue(K_ACT, 0, 1'b0, 4, "R7 rc");                         // t19
        issue(K_ACT, 0, 1'b0, 0, "R7 rc at limit");                // t20
        issue(K_WR, 0, 1'b1, 1, "R4 auto-pre write rcd");          // t21
        idle(1);                                                   // t22
        issue(K_WR, 0, 1'b1, 0, "R9 auto-pre write");              // t23
        issue(K_RD, 0, 1'b0, 9, "R9 bank idle after auto-pre");    // t24
        issue(K_MRS, 0, 1'b0, 6, "R10 mode write during dal");     // t25
        idle(7);                                                   // t26-t32
        issue(K_ACT, 0, 1'b0, 6, "R9 dal");                        // t33
        issue(K_MRS, 0, 1'b0, 0, "R10 mode write legal");          // t34
        issue(K_REF, 0, 1'b0, 7, "R10 mrd");                       // t35
        issue(K_REF, 0, 1'b0, 0, "R11 refresh legal");             // t36
        issue(K_ACT, 2, 1'b0, 11, "R11 rfc");                      // t37
        idle(15);                                                  // t38-t52
        issue(K_ACT, 2, 1'b0, 0, "R11 rfc at limit");              // t53
        issue(K_RD, 2, 1'b0, 1, "R4 read rcd bank2");              // t54
        idle(3);                                                   // t55-t57
        issue(K_RD, 2, 1'b1, 0, "R9 auto-pre read");               // t58
        issue(K_PRE, 2, 1'b0, 0, "R5 precharge idle bank");        // t59
        idle(8);                                                   // t60-t67
        issue(K_ACT, 2, 1'b0, 2, "R9/R5 implicit rp");             // t68
        issue(K_ACT, 2, 1'b0, 4, "R9 rc after auto-pre read");     // t69
        idle(2);
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule